// File: doc/BRIEF.md
# Oversampled Window Edge Locator

This block takes one snapshot per bit window from a sampling ring. A snapshot is 32 data samples, one for each successive tap, with tap 0 the earliest. A single-cycle strobe marks the end of a window. On that strobe the snapshot is copied into a holding register. The previous window's last sample is kept so that it can act as the left neighbour of tap 0.

The held pattern passes through a three-sample majority filter that removes lone flipped samples, such as noise spikes or metastable captures. A scan then looks for level changes that settle. A qualified change is reported with its tap index one clock after the strobe. A digital phase-tracking loop can use that index as its phase error source. When one window contains several qualified changes, the earliest is reported and a flag is raised.

Top module: `window_edge_locator`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `edge_found`, `edge_multi` and `edge_tap` are 0. The remembered previous-window last sample is also cleared to 0.
- R2: `samples` is taken only on a clock edge where `win_stb` is 1. Changing `samples` at any other time has no effect on any output, and none on the remembered last sample.
- R3: The result of a window appears at the clock edge after the edge that captured the strobe. `edge_found` stays high for one cycle only, unless the next strobe follows directly.
- R4: A held sample is replaced by its neighbours' value when it differs from both neighbours. This uses a majority of three over taps i-1, i and i+1.
- R5: The left neighbour of tap 0 is tap 31 of the previous strobed window. Tap 31 has no right neighbour and is never altered by the filter.
- R6: After filtering, tap i (0 to 29) carries a valid transition when its level differs from tap i-1 and taps i+1 and i+2 both equal tap i. Changes at taps 30 or 31 are never reported.
- R7: A change between the previous window's tap 31 and the current filtered tap 0 is reported as tap 0, under the same two-tap hold rule.
- R8: When more than one tap qualifies, `edge_tap` gives the lowest tap index and `edge_multi` is 1 together with `edge_found`.
- R9: When no tap qualifies, `edge_found` and `edge_multi` are 0 and `edge_tap` keeps its previous value.
- R10: Rising (0 to 1) and falling (1 to 0) changes qualify alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| win_stb | input | 1 | End-of-window strobe, one cycle |
| samples | input | 32 | Snapshot; bit i is tap i |
| edge_found | output | 1 | A qualified change was found in the last window |
| edge_tap | output | 5 | Tap index of the earliest qualified change |
| edge_multi | output | 1 | More than one tap qualified |

## Verification
Two checks can resolve in the same window: the test across the window boundary, which uses the remembered last sample, and the search for changes inside the window. To provoke both at once, the stimulus ends one window high and starts the next with zeros followed by a short high run. The boundary change and the interior changes then all qualify together. The expected result is tap 0 with the multiple flag set. This shows that the boundary term takes priority and is still counted with the others.

// File: rtl/wel_pkg.sv
package wel_pkg;

    parameter int unsigned TAPS_DEF = 32;
    parameter int unsigned RUN_DEF  = 2;

    // held window plus the sample that precedes its tap 0
    typedef struct packed {
        logic                left;
        logic [TAPS_DEF-1:0] win;
    } held_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic more_than_one(input logic [TAPS_DEF-1:0] v);
        return |(v & (v - 1'b1));
    endfunction

endpackage

// File: rtl/wel_hold_reg.sv
module wel_hold_reg
    import wel_pkg::*;
#(
    parameter int unsigned TAPS = TAPS_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stb_i,
    input  logic [TAPS-1:0] samples_i,
    output logic [TAPS-1:0] win_o,
    output logic            left_o,
    output logic            pend_o
);

    logic [TAPS-1:0] win_q;
    logic            left_q;
    logic            pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            left_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= stb_i;
            if (stb_i) begin
                left_q <= win_q[TAPS-1];
                win_q  <= samples_i;
            end
        end
    end

    assign win_o  = win_q;
    assign left_o = left_q;
    assign pend_o = pend_q;

endmodule

// File: rtl/wel_glitch_filter.sv
module wel_glitch_filter
    import wel_pkg::*;
#(
    parameter int unsigned TAPS = TAPS_DEF
) (
    input  logic [TAPS-1:0] raw_i,
    input  logic            left_i,
    output logic [TAPS-1:0] clean_o
);

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        if (i == TAPS - 1) begin : g_last
            assign clean_o[i] = raw_i[i];
        end else if (i == 0) begin : g_first
            assign clean_o[i] = maj3(left_i, raw_i[0], raw_i[1]);
        end else begin : g_mid
            assign clean_o[i] = maj3(raw_i[i-1], raw_i[i], raw_i[i+1]);
        end
    end

endmodule

// File: rtl/wel_edge_scan.sv
module wel_edge_scan
    import wel_pkg::*;
#(
    parameter int unsigned TAPS  = TAPS_DEF,
    parameter int unsigned RUN   = RUN_DEF,
    localparam int unsigned TAP_W = $clog2(TAPS)
) (
    input  logic [TAPS-1:0]  clean_i,
    input  logic             left_i,
    output logic             hit_o,
    output logic             multi_o,
    output logic [TAP_W-1:0] tap_o
);

    logic [TAPS:0]   ext;
    logic [TAPS-1:0] mark;

    assign ext = {clean_i, left_i};

    for (genvar i = 0; i < TAPS; i++) begin : g_mark
        if (i + RUN < TAPS) begin : g_ok
            logic hold_ok;
            always_comb begin
                hold_ok = 1'b1;
                for (int k = 1; k <= RUN; k++) begin
                    if (clean_i[i+k] != clean_i[i]) hold_ok = 1'b0;
                end
            end
            assign mark[i] = (ext[i+1] != ext[i]) && hold_ok;
        end else begin : g_none
            assign mark[i] = 1'b0;
        end
    end

    always_comb begin
        tap_o = '0;
        for (int i = TAPS - 1; i >= 0; i--) begin
            if (mark[i]) tap_o = TAP_W'(i);
        end
    end

    assign hit_o   = |mark;
    assign multi_o = |(mark & (mark - 1'b1));

endmodule

// File: rtl/window_edge_locator.sv
module window_edge_locator
    import wel_pkg::*;
#(
    parameter int unsigned TAPS  = TAPS_DEF,
    parameter int unsigned RUN   = RUN_DEF,
    localparam int unsigned TAP_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             win_stb,
    input  logic [TAPS-1:0]  samples,
    output logic             edge_found,
    output logic [TAP_W-1:0] edge_tap,
    output logic             edge_multi
);

    logic [TAPS-1:0]  held_win;
    logic             held_left;
    logic             pend;
    logic [TAPS-1:0]  clean;
    logic             hit;
    logic             multi;
    logic [TAP_W-1:0] tap;

    wel_hold_reg #(.TAPS(TAPS)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .stb_i    (win_stb),
        .samples_i(samples),
        .win_o    (held_win),
        .left_o   (held_left),
        .pend_o   (pend)
    );

    wel_glitch_filter #(.TAPS(TAPS)) u_filt (
        .raw_i  (held_win),
        .left_i (held_left),
        .clean_o(clean)
    );

    wel_edge_scan #(.TAPS(TAPS), .RUN(RUN)) u_scan (
        .clean_i(clean),
        .left_i (held_left),
        .hit_o  (hit),
        .multi_o(multi),
        .tap_o  (tap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_found <= 1'b0;
            edge_multi <= 1'b0;
            edge_tap   <= '0;
        end else begin
            edge_found <= pend & hit;
            edge_multi <= pend & multi;
            if (pend && hit) edge_tap <= tap;
        end
    end

endmodule

// File: rtl/wel_checker.sv
module wel_checker #(
    parameter int unsigned TAPS  = 32,
    parameter int unsigned RUN   = 2,
    parameter int unsigned TAP_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             win_stb,
    input logic             edge_found,
    input logic [TAP_W-1:0] edge_tap,
    input logic             edge_multi
);

    a_r3_found_after_strobe: assert property (@(posedge clk) disable iff (rst)
        edge_found |-> $past(win_stb, 2));

    a_r8_multi_with_found: assert property (@(posedge clk) disable iff (rst)
        edge_multi |-> edge_found);

    a_r9_tap_holds: assert property (@(posedge clk) disable iff (rst)
        !edge_found |-> $stable(edge_tap));

    a_r6_tap_in_range: assert property (@(posedge clk) disable iff (rst)
        edge_found |-> (32'(edge_tap) < TAPS - RUN));

    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!edge_found && !edge_multi && edge_tap == '0));

endmodule

bind window_edge_locator wel_checker #(
    .TAPS (TAPS),
    .RUN  (RUN),
    .TAP_W(TAP_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .win_stb   (win_stb),
    .edge_found(edge_found),
    .edge_tap  (edge_tap),
    .edge_multi(edge_multi)
);

// File: tb/test_window_edge_locator.sv
module test_window_edge_locator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        win_stb = 1'b0;
    logic [31:0] samples = '0;
    logic        edge_found;
    logic [4:0]  edge_tap;
    logic        edge_multi;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    window_edge_locator i_window_edge_locator (
        .clk       (clk),
        .rst       (rst),
        .win_stb   (win_stb),
        .samples   (samples),
        .edge_found(edge_found),
        .edge_tap  (edge_tap),
        .edge_multi(edge_multi)
    );

    // {samples, found, multi, tap}; the order matters because tap 31 carries over
    localparam int NV = 12;
    localparam logic [38:0] VEC [NV] = '{
        {32'h0000_0000, 1'b0, 1'b0, 5'd0 },  // R9 quiet
        {32'hFFFF_FF00, 1'b1, 1'b0, 5'd8 },  // R10 rising at 8
        {32'h0000_00F0, 1'b1, 1'b1, 5'd0 },  // R7 R8 boundary + interior
        {32'h0000_0400, 1'b0, 1'b0, 5'd0 },  // R4 lone glitch removed
        {32'h8000_0000, 1'b0, 1'b0, 5'd0 },  // R5 R6 tap 31 kept, not reported
        {32'hFFFF_FFFE, 1'b0, 1'b0, 5'd0 },  // R5 tap 0 glitch vs previous tap 31
        {32'h0000_FFFF, 1'b1, 1'b0, 5'd16},  // R10 falling at 16
        {32'hE000_0000, 1'b1, 1'b0, 5'd29},  // R6 last valid tap
        {32'h3FFF_FFFF, 1'b0, 1'b0, 5'd29},  // R6 change at 30 ignored, R9 hold
        {32'h0000_0060, 1'b1, 1'b0, 5'd7 },  // R6 two-tap pulse, fall at 7
        {32'hFFF0_0002, 1'b1, 1'b0, 5'd20},  // R4 glitch at 1, edge at 20
        {32'h0000_0001, 1'b1, 1'b0, 5'd1 }   // R5 tap 0 kept by previous 1
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_window(input logic [31:0] s);
        @(negedge clk);
        samples = s;
        win_stb = 1'b1;
        @(negedge clk);
        win_stb = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 found", 32'(edge_found), 0);
        check("R1 multi", 32'(edge_multi), 0);
        check("R1 tap",   32'(edge_tap),   0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 found after release", 32'(edge_found), 0);

        for (int v = 0; v < NV; v++) begin
            send_window(VEC[v][38:7]);
            check($sformatf("R6 found vec%0d", v), 32'(edge_found), 32'(VEC[v][6]));
            check($sformatf("R8 multi vec%0d", v), 32'(edge_multi), 32'(VEC[v][5]));
            check($sformatf("R9 tap vec%0d",   v), 32'(edge_tap),   32'(VEC[v][4:0]));
        end

        // R3: pulse drops on the next cycle and tap is kept
        @(negedge clk);
        check("R3 pulse ends", 32'(edge_found), 0);
        check("R3 tap kept",   32'(edge_tap),   1);

        // R2: samples moving without a strobe are ignored (held tap 31 stays 0)
        samples = 32'h8000_0000;
        repeat (4) @(negedge clk);
        check("R2 no output change", 32'(edge_found), 0);
        check("R2 tap unchanged",    32'(edge_tap),   1);

        // R3 timing: nothing after one edge, result after the second
        @(negedge clk);
        samples = 32'hFFFF_FFFF;
        win_stb = 1'b1;
        @(negedge clk);
        win_stb = 1'b0;
        check("R3 not early", 32'(edge_found), 0);
        @(negedge clk);
        check("R2 R3 found tap0", 32'(edge_found), 1);
        check("R2 tap0",          32'(edge_tap),   0);

        // R1: reset clears remembered last sample (was 1)
        @(negedge clk);
        send_window(32'h0000_0100);
        check("R7 boundary fall", 32'(edge_tap), 0);
        send_window(32'hFFFF_FFFF);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid reset found", 32'(edge_found), 0);
        check("R1 mid reset tap",   32'(edge_tap),   0);
        rst = 1'b0;
        send_window(32'hFFFF_FFFF);
        check("R1 prev cleared found", 32'(edge_found), 1);
        check("R1 prev cleared tap",   32'(edge_tap),   0);

        // R3 back-to-back strobes each produce a result
        @(negedge clk);
        samples = 32'h0000_F000;
        win_stb = 1'b1;
        @(negedge clk);
        samples = 32'hFFFF_FFC0;
        @(negedge clk);
        win_stb = 1'b0;
        check("R3 first of pair", 32'(edge_tap), 0);
        check("R8 first of pair multi", 32'(edge_multi), 1);
        @(negedge clk);
        check("R3 second of pair found", 32'(edge_found), 1);
        check("R3 second of pair tap",   32'(edge_tap),   6);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule